// File: doc/BRIEF.md
# Indirect Extended RAM Access Port

This block places a byte-wide window onto an internal RAM behind a small register bus. The host loads a two-byte address pointer through a low-byte register and a high-byte register. It then reads or writes a single data-port register. Each data-port access reaches the RAM byte that the pointer selects. A burst-enable bit in an extended control register makes the pointer step forward by one after every data-port access. With that bit set, the host can stream through memory without reloading the pointer.

The RAM depth is a power-of-two parameter; the intended sizes are 128, 2048, 4096 or 8192 bytes. At 128 bytes the high pointer byte carries no address bits. The port registers are decoded only while the bank-select input is high. That input stands in for the bank-select bit of the wider register file.

Top module: `xram_port`

## Requirements
- R1: After reset the pointer is zero, burst mode is off and `readData` is 0x00.
- R2: Register offsets are 0x50 for the pointer low byte, 0x51 for the pointer high byte, 0x53 for the data port and 0x4A for the extended control register. Only bit 5 (burst enable) of 0x4A is stored. A read of 0x4A returns that bit in position 5 and zeros elsewhere. Reads of 0x50 and 0x51 return the stored pointer bits.
- R3: A read captures the value into `readData` at the clock edge that ends the cycle in which `readEn` is high. `readData` then holds that value until the next read.
- R4: A data-port write stores `writeData` at the current pointer. A data-port read returns the byte at the current pointer.
- R5: With burst enabled, every data-port read or write advances the pointer by one after the access.
- R6: With burst disabled, data-port accesses leave the pointer unchanged, so repeated accesses reach the same byte.
- R7: The pointer wraps from address DEPTH-1 to zero.
- R8: Pointer bits at or above log2(DEPTH) are ignored. They read back as zero, and pointer values that differ only in those bits select the same byte.
- R9: A pointer byte write takes effect at once, so the data-port access in the next cycle uses the new address.
- R10: While `bankSel` is low, writes change neither the pointer, the RAM nor the burst bit, and every read returns 0x00.
- R11: Accesses to unmapped offsets have no effect, and reads of them return 0x00.
- R12: When `writeEn` and `readEn` are high in the same cycle, the write is carried out and the read is ignored, so `readData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 1 | High while the extended register bank is selected |
| regAddr | input | 8 | Register offset |
| writeEn | input | 1 | Write strobe, one cycle per access |
| readEn | input | 1 | Read strobe, one cycle per access |
| writeData | input | 8 | Write data |
| readData | output | 8 | Registered read data |

## Verification
Every read result is due exactly one clock edge after the cycle in which `readEn` is high. The bench drives each strobe on a falling edge for one cycle and samples `readData` on the following falling edge, after that single register has loaded. Pointer and RAM effects are due at the same edge as the write that causes them. The bench observes them only through later reads of 0x50, 0x51 and 0x53, so no check depends on the order of processes at an edge. The bank-off and unmapped cases are followed by reads with the bank selected, which expose any pointer, burst or RAM change.

// File: rtl/xram_pkg.sv
package xram_pkg;

  localparam logic [7:0] OFS_PTR_LO = 8'h50;
  localparam logic [7:0] OFS_PTR_HI = 8'h51;
  localparam logic [7:0] OFS_DATA   = 8'h53;
  localparam logic [7:0] OFS_XCTRL  = 8'h4A;
  localparam int         BURST_BIT  = 5;

  typedef struct packed {
    logic loWr;
    logic hiWr;
    logic cfgWr;
    logic dataWr;
    logic loRd;
    logic hiRd;
    logic cfgRd;
    logic dataRd;
    logic anyRd;
  } portStrobe_t;

endpackage

// File: rtl/xram_ctrl.sv
module xram_ctrl
  import xram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bankSel,
  input  logic [7:0]  regAddr,
  input  logic        writeEn,
  input  logic        readEn,
  output portStrobe_t strobe
);

  logic hitLo, hitHi, hitData, hitCfg;
  logic doWrite, doRead;

  always_comb begin
    hitLo   = bankSel && (regAddr == OFS_PTR_LO);
    hitHi   = bankSel && (regAddr == OFS_PTR_HI);
    hitData = bankSel && (regAddr == OFS_DATA);
    hitCfg  = bankSel && (regAddr == OFS_XCTRL);
    doWrite = writeEn;
    doRead  = readEn && !writeEn;
  end

  always_comb begin
    strobe        = '0;
    strobe.loWr   = doWrite && hitLo;
    strobe.hiWr   = doWrite && hitHi;
    strobe.cfgWr  = doWrite && hitCfg;
    strobe.dataWr = doWrite && hitData;
    strobe.loRd   = doRead && hitLo;
    strobe.hiRd   = doRead && hitHi;
    strobe.cfgRd  = doRead && hitCfg;
    strobe.dataRd = doRead && hitData;
    strobe.anyRd  = doRead;
  end

  // At most one targeted strobe per cycle (R12 write priority, R2 decode)
  assert_one_target_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loWr, strobe.hiWr, strobe.cfgWr, strobe.dataWr,
              strobe.loRd, strobe.hiRd, strobe.cfgRd, strobe.dataRd}));

  // Nothing reaches the datapath registers while the bank is off (R10)
  assert_bank_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |-> ($countones({strobe.loWr, strobe.hiWr, strobe.cfgWr,
                              strobe.dataWr, strobe.dataRd}) == 0));

endmodule

// File: rtl/xram_datapath.sv
module xram_datapath
  import xram_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t strobe,
  input  logic [7:0]  writeData,
  output logic [7:0]  readData,
  output logic        burstOn,
  output logic [$clog2(DEPTH)-1:0] ptrOut
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PADW = 16 - AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr, nextPtr;
  logic [15:0]   ptrWide, loadWide;
  logic          burst;
  logic [7:0]    rdMux;
  logic          dataAccess;

  assign ptrWide    = {{PADW{1'b0}}, ptr};
  assign dataAccess = strobe.dataWr || strobe.dataRd;
  assign ptrOut     = ptr;
  assign burstOn    = burst;

  always_comb begin
    loadWide = ptrWide;
    if (strobe.loWr) loadWide[7:0]  = writeData;
    if (strobe.hiWr) loadWide[15:8] = writeData;
    nextPtr = loadWide[AW-1:0];
    if (dataAccess && burst) nextPtr = AW'(ptr + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr   <= '0;
      burst <= 1'b0;
    end else begin
      ptr <= nextPtr;
      if (strobe.cfgWr) burst <= writeData[BURST_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.dataWr) mem[ptr] <= writeData;
  end

  always_comb begin
    rdMux = 8'h00;
    if (strobe.loRd)   rdMux = ptrWide[7:0];
    if (strobe.hiRd)   rdMux = ptrWide[15:8];
    if (strobe.cfgRd)  rdMux = 8'(burst) << BURST_BIT;
    if (strobe.dataRd) rdMux = mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             readData <= 8'h00;
    else if (strobe.anyRd) readData <= rdMux;
  end

  // Burst stepping after a data access (R5, wrap R7)
  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccess && burst) |=> (ptr == AW'($past(ptr) + 1'b1)));

  // Pointer held across data accesses without burst (R6)
  assert_no_burst_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccess && !burst) |=> $stable(ptr));

  // Pointer only moves on a pointer write or data access (R10, R11)
  assert_ptr_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loWr || strobe.hiWr || dataAccess) |=> $stable(ptr));

  // Read data only changes after a read cycle (R3)
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.anyRd |=> $stable(readData));

endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bankSel,
  input  logic [7:0] regAddr,
  input  logic       writeEn,
  input  logic       readEn,
  input  logic [7:0] writeData,
  output logic [7:0] readData
);

  localparam int AW = $clog2(DEPTH);

  portStrobe_t   strobe;
  logic          burstOn;
  logic [AW-1:0] ptrNow;

  xram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bankSel (bankSel),
    .regAddr (regAddr),
    .writeEn (writeEn),
    .readEn  (readEn),
    .strobe  (strobe)
  );

  xram_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .writeData (writeData),
    .readData  (readData),
    .burstOn   (burstOn),
    .ptrOut    (ptrNow)
  );

  // Bank-off reads return zero one edge later (R10)
  assert_bank_off_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!bankSel && readEn && !writeEn) |=> (readData == 8'h00));

  // Bank-off traffic leaves pointer and burst bit alone (R10)
  assert_bank_off_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |=> ($stable(ptrNow) && $stable(burstOn)));

endmodule

// File: tb/sim_xram_port.sv
module sim_xram_port;

  localparam int DEPTH = 2048;
  localparam logic [7:0] A_LO = 8'h50, A_HI = 8'h51, A_DATA = 8'h53, A_CFG = 8'h4A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bankSel = 1'b1;
  logic [7:0] regAddr = '0;
  logic writeEn = 1'b0;
  logic readEn = 1'b0;
  logic [7:0] writeData = '0;
  logic [7:0] readData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xram_port #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .regAddr(regAddr),
    .writeEn(writeEn), .readEn(readEn), .writeData(writeData),
    .readData(readData)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; writeData = d; writeEn = 1'b1;
    @(negedge clk);
    writeEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; readEn = 1'b1;
    @(negedge clk);
    readEn = 1'b0;
    d = readData;
  endtask

  task automatic setPtr(input logic [15:0] p);
    busWrite(A_LO, p[7:0]);
    busWrite(A_HI, p[15:8]);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 readData after reset", readData, 8'h00);
    busRead(A_LO, v);  check("R1 ptr low", v, 8'h00);
    busRead(A_HI, v);  check("R1 ptr high", v, 8'h00);
    busRead(A_CFG, v); check("R1 burst off", v, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] v;
    setPtr(16'h0534);
    busRead(A_LO, v);  check("R2 low readback", v, 8'h34);
    busRead(A_HI, v);  check("R2 high readback", v, 8'h05);
    busWrite(A_CFG, 8'hFF);
    busRead(A_CFG, v); check("R2 cfg only bit5", v, 8'h20);
    busWrite(A_CFG, 8'h00);
    busRead(A_CFG, v); check("R2 cfg cleared", v, 8'h00);
  endtask

  task automatic testSingle();
    logic [7:0] v;
    setPtr(16'h0123);
    busWrite(A_DATA, 8'hA5);
    busRead(A_DATA, v); check("R4 read back", v, 8'hA5);
    busRead(A_DATA, v); check("R6 repeat read same byte", v, 8'hA5);
    busWrite(A_DATA, 8'h11);
    busWrite(A_DATA, 8'h22);
    busRead(A_DATA, v); check("R6 overwrite same byte", v, 8'h22);
    busRead(A_LO, v);   check("R6 ptr low unchanged", v, 8'h23);
    busRead(A_HI, v);   check("R6 ptr high unchanged", v, 8'h01);
    repeat (3) @(negedge clk);
    check("R3 readData held", readData, 8'h01);
  endtask

  task automatic testBurst();
    logic [7:0] v;
    busWrite(A_CFG, 8'h20);
    setPtr(16'h0010);
    for (int i = 0; i < 4; i++) busWrite(A_DATA, 8'h40 + 8'(i));
    busRead(A_LO, v); check("R5 ptr after burst writes", v, 8'h14);
    setPtr(16'h0010);
    for (int i = 0; i < 4; i++) begin
      busRead(A_DATA, v);
      check("R5 burst read stream", v, 8'h40 + 8'(i));
    end
    busRead(A_LO, v); check("R5 ptr after burst reads", v, 8'h14);
  endtask

  task automatic testWrap();
    logic [7:0] v;
    setPtr(16'h07FE);
    busWrite(A_DATA, 8'hE1);
    busWrite(A_DATA, 8'hE2);
    busWrite(A_DATA, 8'hE3);
    busRead(A_LO, v); check("R7 wrapped ptr low", v, 8'h01);
    busRead(A_HI, v); check("R7 wrapped ptr high", v, 8'h00);
    busWrite(A_CFG, 8'h00);
    setPtr(16'h0000);
    busRead(A_DATA, v); check("R7 byte at zero", v, 8'hE3);
    setPtr(16'h07FF);
    busRead(A_DATA, v); check("R7 byte at last", v, 8'hE2);
  endtask

  task automatic testHighBits();
    logic [7:0] v;
    busWrite(A_HI, 8'hFF);
    busRead(A_HI, v); check("R8 high bits masked", v, 8'h07);
    setPtr(16'h0700);
    busWrite(A_DATA, 8'h5C);
    setPtr(16'h0F00);
    busRead(A_DATA, v); check("R8 alias selects same byte", v, 8'h5C);
  endtask

  task automatic testImmediate();
    logic [7:0] v;
    setPtr(16'h0200);
    busWrite(A_DATA, 8'h71);
    busWrite(A_LO, 8'h01);
    busWrite(A_DATA, 8'h72);
    busWrite(A_LO, 8'h00);
    busRead(A_DATA, v); check("R9 first byte", v, 8'h71);
    busWrite(A_LO, 8'h01);
    busRead(A_DATA, v); check("R9 new pointer used next cycle", v, 8'h72);
  endtask

  task automatic testBankOff();
    logic [7:0] v;
    busWrite(A_CFG, 8'h20);
    setPtr(16'h0300);
    busWrite(A_DATA, 8'h3C);
    setPtr(16'h0300);
    bankSel = 1'b0;
    busWrite(A_LO, 8'h99);
    busWrite(A_DATA, 8'h77);
    busWrite(A_CFG, 8'h00);
    busRead(A_LO, v);   check("R10 bank off reads zero", v, 8'h00);
    busRead(A_DATA, v); check("R10 bank off data zero", v, 8'h00);
    bankSel = 1'b1;
    busRead(A_LO, v);   check("R10 ptr untouched", v, 8'h00);
    busRead(A_CFG, v);  check("R10 burst untouched", v, 8'h20);
    busRead(A_DATA, v); check("R10 ram untouched", v, 8'h3C);
    busWrite(A_CFG, 8'h00);
  endtask

  task automatic testUnmapped();
    logic [7:0] v;
    setPtr(16'h0123);
    busWrite(8'h52, 8'hAA);
    busWrite(8'h0A, 8'h10);
    busRead(8'h52, v); check("R11 unmapped read", v, 8'h00);
    busRead(A_LO, v);  check("R11 ptr unchanged", v, 8'h23);
    busRead(A_CFG, v); check("R11 burst unchanged", v, 8'h00);
    busRead(A_DATA, v); check("R11 ram unchanged", v, 8'h22);
  endtask

  task automatic testBothStrobes();
    logic [7:0] v;
    setPtr(16'h0400);
    busRead(A_HI, v);
    @(negedge clk);
    regAddr = A_DATA; writeData = 8'h9E; writeEn = 1'b1; readEn = 1'b1;
    @(negedge clk);
    writeEn = 1'b0; readEn = 1'b0;
    check("R12 read ignored", readData, 8'h04);
    busRead(A_DATA, v); check("R12 write performed", v, 8'h9E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testSingle();
    testBurst();
    testWrap();
    testHighBits();
    testImmediate();
    testBankOff();
    testUnmapped();
    testBothStrobes();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule